// File: doc/BRIEF.md
# Break-Filtering Serial Repeater

This block sits between two asynchronous serial links and regenerates the incoming traffic on its outgoing line. Each character that the input receiver assembles is sent again, freshly framed, by a local transmitter. The value of the block lies in how it treats a long SPACE on the input. A receiver that samples only at bit centres reports a character of all zeros with a bad stop bit both for a real line break and for a short burst of SPACE or a ringing line. The repeater tells these two apart and forwards only the real breaks.

A continuous-level watcher runs beside the receiver. It starts timing when the receiver detects a start edge, and it notes any MARK level on the line, including pulses that fall between the receiver's sample points. A zero character with a framing error is parked in a one-entry holding register until the watcher decides. If the line stayed solidly at SPACE for two full frames plus three bit times, the transmitter emits its own break, a timed SPACE followed by an equally long MARK. Otherwise the parked value leaves as an ordinary zero character. Later characters wait behind the parked one, so arrival order is kept. The line rate is fixed by the parameter `TICK_DIV`: the receiver works on a 16x oversampling tick every `TICK_DIV` clocks, so one bit lasts `16*TICK_DIV` clocks.

Top module: `break_filter_repeater`

## Requirements
- R1: While reset is asserted and directly after it, `txd` is 1 (MARK) and `overrun` is 0.
- R2: A well-framed character on `rxd` leaves on `txd` with the same value. The frame is one start bit at 0, `DATA_BITS` data bits LSB first and one stop bit at 1, each bit `16*TICK_DIV` clocks long.
- R3: A non-zero character received with a stop bit of 0 is still sent on `txd` unchanged, with a correct stop bit.
- R4: An all-zero character with a stop bit of 0, after which `rxd` returns to 1 before the break threshold, is sent as a correctly framed zero character.
- R5: An all-zero character with a bad stop bit is sent as a correctly framed zero character whenever `rxd` was at 1 for any clock after the start edge. This holds even for a pulse between sample points on an otherwise long SPACE.
- R6: A break is genuine if `rxd` stays at 0 for every clock after start detection until `BRK_BITS = 2*(DATA_BITS+2)+3` bit times have passed. A genuine break makes `txd` hold 0 for `BRK_BITS` bit times and then 1 for at least `BRK_BITS` bit times before the next character starts.
- R7: Characters leave in the order they arrived. A parked zero character is not overtaken by a later one.
- R8: If a character completes while the holding register is still full, it is dropped and `overrun` goes to 1 and stays there until reset.
- R9: A low pulse on `rxd` that ends before the middle of the start bit is rejected and produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Incoming serial line, idle 1 |
| txd | output | 1 | Regenerated serial line, idle 1 |
| overrun | output | 1 | Sticky flag: a character was lost because the holding register was full |

## Verification
The bench builds the repeater with `TICK_DIV = 2`, eight data bits and two synchroniser stages. A bit is then 32 clocks and the break threshold 736 clocks, so genuine breaks, the MARK gap after them and an overrun during an output break each fit in a few thousand cycles. At this rate there is enough room between sample points to place a two-clock MARK pulse that the centre-sampling receiver never sees and only the level watcher catches.

// File: rtl/brkrep_pkg.sv
package brkrep_pkg;

   typedef enum logic [1:0] {
      RX_HUNT,
      RX_START,
      RX_BITS,
      RX_WAIT_MARK
   } rx_state_t;

   typedef enum logic [1:0] {
      TX_IDLE,
      TX_FRAME,
      TX_BRK_SPACE,
      TX_BRK_MARK
   } tx_state_t;

   typedef enum logic [1:0] {
      HK_PLAIN,
      HK_PEND,
      HK_BREAK
   } hold_kind_t;

   localparam int unsigned OVS = 16;

endpackage

// File: rtl/brkrep_tick.sv
module brkrep_tick #(
   parameter int unsigned TICK_DIV = 27
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

   logic [CW-1:0] div_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            div_q <= '0;
      else if (div_q == LAST) div_q <= '0;
      else                   div_q <= div_q + 1'b1;
   end

   assign tick = (div_q == LAST);

endmodule

// File: rtl/brkrep_rx.sv
module brkrep_rx
   import brkrep_pkg::*;
#(
   parameter int unsigned DATA_BITS   = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 rxd,
   output logic                 line_o,
   output logic                 frame_start,
   output logic                 byte_valid,
   output logic [DATA_BITS-1:0] byte_o,
   output logic                 frame_err
);
   localparam int unsigned BW = $clog2(DATA_BITS + 1);

   logic [SYNC_STAGES-1:0] sync_q;
   rx_state_t              st;
   logic [3:0]             phase;
   logic [BW-1:0]          bitn;
   logic [DATA_BITS-1:0]   shreg;

   always_ff @(posedge clk) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
   end
   assign line_o = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= RX_HUNT;
         phase       <= '0;
         bitn        <= '0;
         shreg       <= '0;
         byte_valid  <= 1'b0;
         frame_err   <= 1'b0;
         frame_start <= 1'b0;
      end else begin
         byte_valid  <= 1'b0;
         frame_start <= 1'b0;
         if (tick) begin
            unique case (st)
               RX_HUNT: begin
                  if (!line_o) begin
                     st          <= RX_START;
                     phase       <= '0;
                     frame_start <= 1'b1;
                  end
               end
               RX_START: begin
                  if (phase == 4'd7) begin
                     phase <= '0;
                     bitn  <= '0;
                     st    <= line_o ? RX_HUNT : RX_BITS;
                  end else begin
                     phase <= phase + 1'b1;
                  end
               end
               RX_BITS: begin
                  if (phase == 4'd15) begin
                     phase <= '0;
                     if (bitn == BW'(DATA_BITS)) begin
                        byte_valid <= 1'b1;
                        frame_err  <= !line_o;
                        st         <= line_o ? RX_HUNT : RX_WAIT_MARK;
                     end else begin
                        shreg <= {line_o, shreg[DATA_BITS-1:1]};
                        bitn  <= bitn + 1'b1;
                     end
                  end else begin
                     phase <= phase + 1'b1;
                  end
               end
               RX_WAIT_MARK: begin
                  if (line_o) st <= RX_HUNT;
               end
               default: st <= RX_HUNT;
            endcase
         end
      end
   end

   assign byte_o = shreg;

   // R2: a completed character is reported for exactly one clock
   a_r2_valid_single : assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |=> !byte_valid);

   // R9: a start edge is only followed by data sampling after start confirmation
   a_r9_start_from_hunt : assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (st == RX_START));

endmodule

// File: rtl/brkrep_judge.sv
module brkrep_judge #(
   parameter int unsigned THRESH_CLKS = 9936
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line,
   input  logic frame_start,
   output logic seen_mark,
   output logic solid_space
);
   localparam int unsigned CW = $clog2(THRESH_CLKS + 1);
   localparam logic [CW-1:0] LIMIT = CW'(THRESH_CLKS);

   logic [CW-1:0] run_q;
   logic          mark_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= '0;
         mark_q <= 1'b1;
      end else if (frame_start) begin
         run_q  <= '0;
         mark_q <= 1'b0;
      end else if (line) begin
         mark_q <= 1'b1;
      end else if (!mark_q && run_q != LIMIT) begin
         run_q <= run_q + 1'b1;
      end
   end

   assign seen_mark   = mark_q;
   assign solid_space = !mark_q && (run_q == LIMIT);

   // R5: once a MARK level is seen, it stays recorded until the next start edge
   a_r5_mark_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (seen_mark && !frame_start) |=> seen_mark);

   // R6: the SPACE run counter never moves once a MARK was seen
   a_r6_run_frozen : assert property (@(posedge clk) disable iff (!rst_n)
      (seen_mark && !frame_start) |=> $stable(run_q));

endmodule

// File: rtl/brkrep_seq.sv
module brkrep_seq
   import brkrep_pkg::*;
#(
   parameter int unsigned DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 byte_valid,
   input  logic [DATA_BITS-1:0] byte_i,
   input  logic                 frame_err,
   input  logic                 seen_mark,
   input  logic                 solid_space,
   input  logic                 tx_ready,
   output logic                 go_char,
   output logic                 go_brk,
   output logic [DATA_BITS-1:0] tx_byte,
   output logic                 overrun
);
   logic                 hold_v;
   hold_kind_t           kind;
   logic [DATA_BITS-1:0] hold_b;
   logic                 dispatch;

   assign dispatch = hold_v && (kind != HK_PEND) && tx_ready;
   assign go_char  = dispatch && (kind == HK_PLAIN);
   assign go_brk   = dispatch && (kind == HK_BREAK);
   assign tx_byte  = hold_b;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_v  <= 1'b0;
         kind    <= HK_PLAIN;
         hold_b  <= '0;
         overrun <= 1'b0;
      end else begin
         if (dispatch) begin
            hold_v <= 1'b0;
         end else if (hold_v && kind == HK_PEND) begin
            if (seen_mark)        kind <= HK_PLAIN;
            else if (solid_space) kind <= HK_BREAK;
         end
         if (byte_valid) begin
            if (hold_v && !dispatch) begin
               overrun <= 1'b1;
            end else begin
               hold_v <= 1'b1;
               hold_b <= byte_i;
               kind   <= (frame_err && byte_i == '0) ? HK_PEND : HK_PLAIN;
            end
         end
      end
   end

   // R8: the overrun flag is sticky until reset
   a_r8_overrun_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   // R7: an undecided zero character keeps its place in the holding register
   a_r7_pend_kept : assert property (@(posedge clk) disable iff (!rst_n)
      (hold_v && kind == HK_PEND && !seen_mark && !solid_space) |=> hold_v);

   // R8: a character that lands on a full register does not replace it
   a_r8_no_replace : assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && hold_v && !dispatch) |=> $stable(hold_b));

endmodule

// File: rtl/brkrep_tx.sv
module brkrep_tx
   import brkrep_pkg::*;
#(
   parameter int unsigned DATA_BITS = 8,
   parameter int unsigned BRK_BITS  = 23
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 go_char,
   input  logic                 go_brk,
   input  logic [DATA_BITS-1:0] data,
   output logic                 ready,
   output logic                 txd
);
   localparam int unsigned FRAME_BITS = DATA_BITS + 2;
   localparam int unsigned CW = $clog2(BRK_BITS + 1);

   tx_state_t             st;
   logic [3:0]            phase;
   logic [CW-1:0]         cnt;
   logic [FRAME_BITS-1:0] shreg;
   logic                  txd_q;

   assign ready = (st == TX_IDLE);
   assign txd   = txd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= TX_IDLE;
         phase <= '0;
         cnt   <= '0;
         shreg <= '1;
         txd_q <= 1'b1;
      end else begin
         unique case (st)
            TX_IDLE: begin
               phase <= '0;
               cnt   <= '0;
               if (go_char) begin
                  shreg <= {1'b1, data, 1'b0};
                  txd_q <= 1'b0;
                  st    <= TX_FRAME;
               end else if (go_brk) begin
                  txd_q <= 1'b0;
                  st    <= TX_BRK_SPACE;
               end
            end
            TX_FRAME: if (tick) begin
               if (phase == 4'd15) begin
                  phase <= '0;
                  if (cnt == CW'(FRAME_BITS - 1)) begin
                     st    <= TX_IDLE;
                     txd_q <= 1'b1;
                  end else begin
                     cnt   <= cnt + 1'b1;
                     txd_q <= shreg[1];
                     shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
                  end
               end else begin
                  phase <= phase + 1'b1;
               end
            end
            TX_BRK_SPACE: if (tick) begin
               if (phase == 4'd15) begin
                  phase <= '0;
                  if (cnt == CW'(BRK_BITS - 1)) begin
                     cnt   <= '0;
                     txd_q <= 1'b1;
                     st    <= TX_BRK_MARK;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end else begin
                  phase <= phase + 1'b1;
               end
            end
            TX_BRK_MARK: if (tick) begin
               if (phase == 4'd15) begin
                  phase <= '0;
                  if (cnt == CW'(BRK_BITS - 1)) st <= TX_IDLE;
                  else                          cnt <= cnt + 1'b1;
               end else begin
                  phase <= phase + 1'b1;
               end
            end
            default: st <= TX_IDLE;
         endcase
      end
   end

   // R1: the idle line is MARK
   a_r1_idle_mark : assert property (@(posedge clk) disable iff (!rst_n)
      (st == TX_IDLE) |-> txd_q);

   // R6: the output line stays SPACE while a break is generated
   a_r6_break_space : assert property (@(posedge clk) disable iff (!rst_n)
      (st == TX_BRK_SPACE) |-> !txd_q);

   // R6: a generated break is always followed by its MARK interval
   a_r6_mark_follows : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == TX_BRK_SPACE && st != TX_BRK_SPACE) |-> (st == TX_BRK_MARK));

   // R2: work is only handed over while the transmitter is idle
   a_r2_go_when_idle : assert property (@(posedge clk) disable iff (!rst_n)
      (go_char || go_brk) |-> (st == TX_IDLE));

endmodule

// File: rtl/break_filter_repeater.sv
module break_filter_repeater
   import brkrep_pkg::*;
#(
   parameter int unsigned TICK_DIV       = 27,
   parameter int unsigned DATA_BITS      = 8,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned BRK_EXTRA_BITS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rxd,
   output logic txd,
   output logic overrun
);
   localparam int unsigned FRAME_BITS  = DATA_BITS + 2;
   localparam int unsigned BRK_BITS    = 2 * FRAME_BITS + BRK_EXTRA_BITS;
   localparam int unsigned THRESH_CLKS = BRK_BITS * OVS * TICK_DIV;

   generate
      if (TICK_DIV < 2) begin : g_chk_div
         $error("TICK_DIV must be at least 2");
      end
      if (DATA_BITS < 5 || DATA_BITS > 9) begin : g_chk_width
         $error("DATA_BITS must lie in 5..9");
      end
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic                 tick;
   logic                 line;
   logic                 frame_start;
   logic                 byte_valid;
   logic [DATA_BITS-1:0] rx_byte;
   logic                 frame_err;
   logic                 seen_mark;
   logic                 solid_space;
   logic                 tx_ready;
   logic                 go_char;
   logic                 go_brk;
   logic [DATA_BITS-1:0] tx_byte;

   brkrep_tick #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   brkrep_rx #(.DATA_BITS(DATA_BITS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
      .line_o(line), .frame_start(frame_start), .byte_valid(byte_valid),
      .byte_o(rx_byte), .frame_err(frame_err)
   );

   brkrep_judge #(.THRESH_CLKS(THRESH_CLKS)) u_judge (
      .clk(clk), .rst_n(rst_n), .line(line), .frame_start(frame_start),
      .seen_mark(seen_mark), .solid_space(solid_space)
   );

   brkrep_seq #(.DATA_BITS(DATA_BITS)) u_seq (
      .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_i(rx_byte),
      .frame_err(frame_err), .seen_mark(seen_mark), .solid_space(solid_space),
      .tx_ready(tx_ready), .go_char(go_char), .go_brk(go_brk),
      .tx_byte(tx_byte), .overrun(overrun)
   );

   brkrep_tx #(.DATA_BITS(DATA_BITS), .BRK_BITS(BRK_BITS)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .go_char(go_char),
      .go_brk(go_brk), .data(tx_byte), .ready(tx_ready), .txd(txd)
   );

endmodule

// File: tb/break_filter_repeater_tb.sv
module break_filter_repeater_tb;
   localparam int TICK_DIV  = 2;
   localparam int DATA_BITS = 8;
   localparam int BIT_CLKS  = 16 * TICK_DIV;
   localparam int BRK_BITS  = 2 * (DATA_BITS + 2) + 3;
   localparam int BRK_CLKS  = BRK_BITS * BIT_CLKS;
   localparam int NVEC      = 12;

   // {stimulus kind, stimulus byte, expected kind, expected byte}
   // stimulus: 0 clean frame, 1 bad stop then short SPACE, 2 long SPACE with a
   // pulse between samples, 3 genuine break, 4 short false start
   // expected: 0 nothing, 1 character, 2 break
   localparam logic [23:0] VEC [0:NVEC-1] = '{
      {4'd0, 8'h55, 4'd1, 8'h55},
      {4'd0, 8'h00, 4'd1, 8'h00},
      {4'd0, 8'hFF, 4'd1, 8'hFF},
      {4'd0, 8'h80, 4'd1, 8'h80},
      {4'd1, 8'h5A, 4'd1, 8'h5A},
      {4'd1, 8'h00, 4'd1, 8'h00},
      {4'd2, 8'h00, 4'd1, 8'h00},
      {4'd3, 8'h00, 4'd2, 8'h00},
      {4'd4, 8'h00, 4'd0, 8'h00},
      {4'd0, 8'hA5, 4'd1, 8'hA5},
      {4'd1, 8'h01, 4'd1, 8'h01},
      {4'd3, 8'h00, 4'd2, 8'h00}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rxd = 1'b1;
   logic txd;
   logic overrun;
   int   cyc = 0;
   int   checks = 0;
   int   fails = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   break_filter_repeater #(.TICK_DIV(TICK_DIV), .DATA_BITS(DATA_BITS)) u_dut (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd), .overrun(overrun)
   );

   // output event log filled by the line monitor
   int         ev_n = 0;
   int         ev_kind [0:63];
   logic [7:0] ev_byte [0:63];
   int         ev_len  [0:63];
   int         ev_t0   [0:63];
   int         ev_t1   [0:63];

   int         m_t0;
   logic [7:0] m_b;
   logic       m_s0, m_sp;

   task automatic log_ev(int k, logic [7:0] b, int len, int t0, int t1);
      if (ev_n < 64) begin
         ev_kind[ev_n] = k; ev_byte[ev_n] = b; ev_len[ev_n] = len;
         ev_t0[ev_n] = t0;  ev_t1[ev_n] = t1;
         ev_n++;
      end
   endtask

   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && txd === 1'b0) begin
            m_t0 = cyc;
            repeat (BIT_CLKS / 2) @(negedge clk);
            m_s0 = txd;
            for (int i = 0; i < DATA_BITS; i++) begin
               repeat (BIT_CLKS) @(negedge clk);
               m_b[i] = txd;
            end
            repeat (BIT_CLKS) @(negedge clk);
            m_sp = txd;
            if (m_s0 !== 1'b0) log_ev(3, m_b, 0, m_t0, cyc);
            else if (m_sp === 1'b1) log_ev(1, m_b, 0, m_t0, cyc);
            else begin
               while (txd === 1'b0) @(negedge clk);
               log_ev((m_b == 8'h00) ? 2 : 3, m_b, cyc - m_t0, m_t0, cyc);
            end
         end
      end
   end

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic hold_line(logic lvl, int clks);
      rxd = lvl;
      repeat (clks) @(negedge clk);
   endtask

   task automatic send_frame(logic [7:0] b, logic stop);
      hold_line(1'b0, BIT_CLKS);
      for (int i = 0; i < DATA_BITS; i++) hold_line(b[i], BIT_CLKS);
      hold_line(stop, BIT_CLKS);
   endtask

   task automatic apply_stim(int kind, logic [7:0] b);
      case (kind)
         0: send_frame(b, 1'b1);
         1: begin send_frame(b, 1'b0); hold_line(1'b0, 2 * BIT_CLKS); end
         2: begin
            hold_line(1'b0, 3 * BIT_CLKS + 2);
            hold_line(1'b1, 2);
            hold_line(1'b0, 27 * BIT_CLKS - 4);
         end
         3: hold_line(1'b0, 30 * BIT_CLKS);
         default: hold_line(1'b0, BIT_CLKS / 4);
      endcase
   endtask

   function automatic string req_of(int kind, logic [7:0] b);
      case (kind)
         0: return "R2";
         1: return (b == 8'h00) ? "R4" : "R3";
         2: return "R5";
         3: return "R6";
         default: return "R9";
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog (all requirements): actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      int n0;
      // R1: reset state
      repeat (5) @(negedge clk);
      check(txd === 1'b1, "R1 txd in reset", int'(txd), 1);
      check(overrun === 1'b0, "R1 overrun in reset", int'(overrun), 0);
      rst_n = 1'b1;
      repeat (40) @(negedge clk);
      check(txd === 1'b1, "R1 txd after reset", int'(txd), 1);

      for (int v = 0; v < NVEC; v++) begin
         int         sk, ek;
         logic [7:0] sb, eb;
         string      rq;
         sk = int'(VEC[v][23:20]); sb = VEC[v][19:12];
         ek = int'(VEC[v][11:8]);  eb = VEC[v][7:0];
         rq = req_of(sk, sb);
         n0 = ev_n;
         apply_stim(sk, sb);
         hold_line(1'b1, 80 * BIT_CLKS);
         if (ek == 0) begin
            check(ev_n == n0, rq, ev_n - n0, 0);
         end else begin
            check(ev_n == n0 + 1, rq, ev_n - n0, 1);
            check(ev_kind[n0] == ek, rq, ev_kind[n0], ek);
            if (ek == 1) check(ev_byte[n0] == eb, rq, int'(ev_byte[n0]), int'(eb));
            else check(ev_len[n0] >= BRK_CLKS - 3 && ev_len[n0] <= BRK_CLKS + 3,
                       rq, ev_len[n0], BRK_CLKS);
         end
      end

      // R6: MARK interval after a generated break delays the next character
      n0 = ev_n;
      hold_line(1'b0, 30 * BIT_CLKS);
      hold_line(1'b1, BIT_CLKS);
      send_frame(8'h3C, 1'b1);
      hold_line(1'b1, 100 * BIT_CLKS);
      check(ev_n == n0 + 2, "R6 events", ev_n - n0, 2);
      check(ev_kind[n0] == 2, "R6 break first", ev_kind[n0], 2);
      check(ev_t0[n0 + 1] - ev_t1[n0] >= BRK_CLKS - 3, "R6 mark gap",
            ev_t0[n0 + 1] - ev_t1[n0], BRK_CLKS);
      check(ev_byte[n0 + 1] == 8'h3C, "R6 char after break", int'(ev_byte[n0 + 1]), 'h3C);

      // R7: parked zero character keeps its place ahead of later ones
      n0 = ev_n;
      send_frame(8'h00, 1'b0);
      hold_line(1'b0, 2 * BIT_CLKS);
      hold_line(1'b1, BIT_CLKS);
      send_frame(8'hA5, 1'b1);
      send_frame(8'h3C, 1'b1);
      hold_line(1'b1, 80 * BIT_CLKS);
      check(ev_n == n0 + 3, "R7 events", ev_n - n0, 3);
      check(ev_byte[n0] == 8'h00 && ev_kind[n0] == 1, "R7 first", int'(ev_byte[n0]), 0);
      check(ev_byte[n0 + 1] == 8'hA5, "R7 second", int'(ev_byte[n0 + 1]), 'hA5);
      check(ev_byte[n0 + 2] == 8'h3C, "R7 third", int'(ev_byte[n0 + 2]), 'h3C);

      // R8: characters arriving during an output break overflow the holding register
      check(overrun === 1'b0, "R8 clear before", int'(overrun), 0);
      n0 = ev_n;
      hold_line(1'b0, 30 * BIT_CLKS);
      hold_line(1'b1, BIT_CLKS);
      send_frame(8'h11, 1'b1);
      send_frame(8'h22, 1'b1);
      send_frame(8'h33, 1'b1);
      hold_line(1'b1, 120 * BIT_CLKS);
      check(overrun === 1'b1, "R8 overrun set", int'(overrun), 1);
      check(ev_n == n0 + 2, "R8 events", ev_n - n0, 2);
      check(ev_byte[n0 + 1] == 8'h11, "R8 kept char", int'(ev_byte[n0 + 1]), 'h11);

      // R1: reset clears the sticky flag and returns the line to MARK
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      check(overrun === 1'b0, "R1 overrun cleared", int'(overrun), 0);
      check(txd === 1'b1, "R1 txd after second reset", int'(txd), 1);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule